// File: doc/BRIEF.md
# Four-Phase Handshake Latch Enable Controller

This block takes the place of a clock for one latch stage in a datapath whose global clock has been replaced by local handshakes. It faces a predecessor on a request/acknowledge pair (`rin`/`ain`) and a successor on a second pair (`rout`/`aout`). It drives the latch enable `lt`. Low on `lt` makes the latch transparent and high makes it opaque. Both pairs follow the return-to-zero order: request up, acknowledge up, request down, acknowledge down.

The controller is a clocked emulation. A fast sampling clock passes `rin` and `aout` through a two-flop synchronizer, and each clock at most one handshake event fires. A parameter selects how much the two sides may overlap:
- The tightly coupled variant has no internal state.
- The partly decoupled variant adds a "stage full" bit.
- The fully decoupled variant adds that bit plus an "output busy" bit.

A second parameter says whether the stage comes out of reset empty or holding a valid item. Along a chain these two reset settings must alternate.

Top module: `hs_latch_ctrl`

## Requirements
- R1: During reset (`rst_n` low at a clock edge), `ain` and `rout` are 0 and `lt` equals the `TOKEN` parameter.
- R2: Of `ain`, `rout` and `lt`, at most one output changes at any clock edge.
- R3: `ain` rises only while `lt` is 1, so an item is held before it is acknowledged. The predecessor is expected to lower `rin` only while `ain` is 1.
- R4: `ain` falls only after `rin` has fallen.
- R5: `rout` rises only while `lt` is 1, so the offered item is held stable.
- R6: `lt` falls only while `rout` and `aout` are both 1, that is, after the successor has captured the item. The successor is expected to change `aout` only to the current value of `rout`.
- R7: In the coupled variant (`MODE`=`HS_SIMPLE`), `ain` never falls while `rout`=1 and `aout`=0. In the other two variants it does so when the successor is slow.
- R8: In the coupled and partly decoupled variants, `lt` rises only while `rout` and `aout` are both 0. In the fully decoupled variant (`HS_FULL`), a new item may be captured while `rout` is still 1.
- R9: With `TOKEN`=1, the stage comes out of reset opaque and raises `rout` without any request. It never acknowledges that preloaded item, so the count of `rout` rises stays one above the count of `ain` rises.
- R10: From the idle state (all handshake signals 0, `lt` 0), `lt` rises at the third clock edge after `rin` rises.
- R11: With `TOKEN`=0, every acknowledged item is forwarded exactly once. Once both sides are idle, the count of `rout` rises equals the count of `ain` rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rin | input | 1 | Request from the predecessor stage |
| ain | output | 1 | Acknowledge to the predecessor stage |
| rout | output | 1 | Request to the successor stage |
| aout | input | 1 | Acknowledge from the successor stage |
| lt | output | 1 | Latch enable: 0 transparent, 1 opaque |

## Verification
Two functions often become eligible in the same cycle:
- In the fully decoupled variant, capturing the next item from the predecessor competes with returning the output request to zero.
- In the partly decoupled variant, the input acknowledge returning to zero competes with the output-side sequencing.

A successor that answers 20 clocks late makes the predecessor's next request wait while the previous item is still on the output. These collisions are then provoked on every item. They are judged by two kinds of check:
- Only one output may move per edge, and the ordering rules must hold.
- The overlap a variant permits must actually be observed, and the overlap it forbids must never be observed.

// File: rtl/hs_pkg.sv
// Package hs_pkg
// Shared types for the handshake latch controller: the variant selector,
// the controller state record and the index of every handshake event.
package hs_pkg;

    typedef enum logic [1:0] {
        HS_SIMPLE = 2'd0,
        HS_SEMI   = 2'd1,
        HS_FULL   = 2'd2
    } hs_mode_e;

    // Controller state; x = stage full, y = output busy, acked = item acknowledged
    typedef struct packed {
        logic ai;
        logic ro;
        logic lt;
        logic x;
        logic y;
        logic acked;
    } hs_state_t;

    // Event indices, lowest index has highest priority
    localparam int EV_LT_R = 0;
    localparam int EV_X_R  = 1;
    localparam int EV_AI_R = 2;
    localparam int EV_AI_F = 3;
    localparam int EV_Y_R  = 4;
    localparam int EV_RO_R = 5;
    localparam int EV_LT_F = 6;
    localparam int EV_X_F  = 7;
    localparam int EV_Y_F  = 8;
    localparam int EV_RO_F = 9;
    localparam int NEV     = 10;

endpackage

// File: rtl/hs_sync.sv
// Module hs_sync
// Two-flop synchronizer, one chain per bit.
// Assumes: inputs are level signals that stay stable for several clocks.
module hs_sync #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic s1, s2;
        // two-stage capture of one asynchronous input
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                s1 <= 1'b0;
                s2 <= 1'b0;
            end else begin
                s1 <= d[i];
                s2 <= s1;
            end
        end
        assign q[i] = s2;
    end
endmodule

// File: rtl/hs_guard.sv
// Module hs_guard
// Enabling conditions of every handshake event for the selected variant.
// Assumes: ri/ao are synchronized; state bits not used by a variant stay 0.
module hs_guard
    import hs_pkg::*;
#(
    parameter hs_mode_e MODE = HS_SEMI
) (
    input  hs_state_t      st,
    input  logic           ri,
    input  logic           ao,
    output logic [NEV-1:0] fire
);
    if (MODE == HS_SIMPLE) begin : g_simple
        // coupled sequencing: input returns only after the output is released
        always_comb begin
            fire          = '0;
            fire[EV_LT_R] = ri & ~st.ai & ~st.lt & ~st.ro & ~ao & ~st.x & ~st.y;
            fire[EV_AI_R] = st.lt & ri & ~st.ai & ~st.acked;
            fire[EV_RO_R] = st.lt & st.acked & ~st.ro & ~ao;
            fire[EV_LT_F] = st.lt & st.ro & ao & st.acked & ~(st.ai & ri);
            fire[EV_AI_F] = st.ai & ~ri & ~st.lt;
            fire[EV_RO_F] = st.ro & ~st.lt & ~st.ai;
        end
    end else if (MODE == HS_SEMI) begin : g_semi
        // one full bit: input side returns to zero on its own
        always_comb begin
            fire          = '0;
            fire[EV_LT_R] = ri & ~st.ai & ~st.lt & ~st.x & ~st.ro & ~ao & ~st.y;
            fire[EV_X_R]  = st.lt & ~st.x;
            fire[EV_AI_R] = st.x & ri & ~st.ai & ~st.acked;
            fire[EV_AI_F] = st.ai & ~ri;
            fire[EV_RO_R] = st.x & ~st.ro & ~ao;
            fire[EV_LT_F] = st.lt & st.ro & ao;
            fire[EV_X_F]  = st.x & ~st.lt & st.ro & ao;
            fire[EV_RO_F] = st.ro & ~st.x;
        end
    end else begin : g_full
        // full and busy bits: next capture overlaps the output return
        always_comb begin
            fire          = '0;
            fire[EV_LT_R] = ri & ~st.ai & ~st.lt & ~st.x & ~st.y;
            fire[EV_X_R]  = st.lt & ~st.x;
            fire[EV_AI_R] = st.x & ri & ~st.ai & ~st.acked;
            fire[EV_AI_F] = st.ai & ~ri;
            fire[EV_Y_R]  = st.x & ~st.y & ~st.ro & ~ao;
            fire[EV_RO_R] = st.y & st.x & ~st.ro & ~ao;
            fire[EV_LT_F] = st.lt & st.y & st.ro & ao;
            fire[EV_X_F]  = st.x & ~st.lt & st.y & st.ro & ao;
            fire[EV_Y_F]  = st.y & ~st.x & st.ro & ao;
            fire[EV_RO_F] = st.ro & ~st.y;
        end
    end
endmodule

// File: rtl/hs_pick.sv
// Module hs_pick
// Fixed-priority picker: grants the lowest-index enabled event only.
// Assumes: nothing; output is one-hot or zero.
module hs_pick #(
    parameter int N = 10
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt
);
    logic [N-1:0] blocked;
    assign blocked[0] = 1'b0;
    for (genvar i = 0; i < N; i++) begin : g_pri
        assign gnt[i] = req[i] & ~blocked[i];
        if (i < N - 1) begin : g_chain
            assign blocked[i+1] = blocked[i] | req[i];
        end
    end
endmodule

// File: rtl/hs_latch_ctrl.sv
// Module hs_latch_ctrl
// Four-phase latch enable controller, emulated on a sampling clock.
// Assumes: neighbours obey return-to-zero signalling; reset held >= 2 clocks.
module hs_latch_ctrl
    import hs_pkg::*;
#(
    parameter hs_mode_e MODE  = HS_SEMI,
    parameter bit       TOKEN = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rin,
    output logic ain,
    output logic rout,
    input  logic aout,
    output logic lt
);
    localparam bit HAS_FULL = (MODE != HS_SIMPLE);

    logic [1:0]     raw_in, syn_in;
    hs_state_t      st;
    logic [NEV-1:0] fire, grant;

    assign raw_in = {rin, aout};

    hs_sync #(.W(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_in),
        .q     (syn_in)
    );

    hs_guard #(.MODE(MODE)) u_guard (
        .st   (st),
        .ri   (syn_in[1]),
        .ao   (syn_in[0]),
        .fire (fire)
    );

    hs_pick #(.N(NEV)) u_pick (
        .req (req_w(fire)),
        .gnt (grant)
    );

    function automatic logic [NEV-1:0] req_w(input logic [NEV-1:0] f);
        return f;
    endfunction

    // apply the single granted event to the state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st.ai    <= 1'b0;
            st.ro    <= 1'b0;
            st.lt    <= TOKEN;
            st.x     <= TOKEN & HAS_FULL;
            st.y     <= 1'b0;
            st.acked <= TOKEN;
        end else begin
            if (grant[EV_LT_R]) begin st.lt <= 1'b1; st.acked <= 1'b0; end
            if (grant[EV_X_R])  st.x  <= 1'b1;
            if (grant[EV_AI_R]) begin st.ai <= 1'b1; st.acked <= 1'b1; end
            if (grant[EV_AI_F]) st.ai <= 1'b0;
            if (grant[EV_Y_R])  st.y  <= 1'b1;
            if (grant[EV_RO_R]) st.ro <= 1'b1;
            if (grant[EV_LT_F]) st.lt <= 1'b0;
            if (grant[EV_X_F])  st.x  <= 1'b0;
            if (grant[EV_Y_F])  st.y  <= 1'b0;
            if (grant[EV_RO_F]) st.ro <= 1'b0;
        end
    end

    assign ain  = st.ai;
    assign rout = st.ro;
    assign lt   = st.lt;

    // ---------------- assertions ----------------
    AST_RESET_STATE: assert property (@(posedge clk) $past(!rst_n) |-> (!ain && !rout && lt == TOKEN)); // R1
    AST_ONE_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({ain, rout, lt} ^ $past({ain, rout, lt})) <= 1); // R2
    AST_ACK_HELD: assert property (@(posedge clk) disable iff (!rst_n) $rose(ain) |-> lt); // R3
    AST_RIN_EARLY: assert property (@(posedge clk) disable iff (!rst_n) $fell(rin) |-> ain); // R3
    AST_ACK_RETURN: assert property (@(posedge clk) disable iff (!rst_n) $fell(ain) |-> !$past(rin)); // R4
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n) $rose(rout) |-> lt); // R5
    AST_OPEN_AFTER_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n) $fell(lt) |-> (rout && aout)); // R6
    AST_AOUT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) !$stable(aout) |-> (aout == rout)); // R6

    if (MODE != HS_FULL) begin : g_chk_capture
        AST_CAPTURE_IDLE: assert property (@(posedge clk) disable iff (!rst_n) $rose(lt) |-> (!rout && !aout)); // R8
    end

    if (MODE == HS_SIMPLE) begin : g_chk_coupled
        AST_COUPLED_RETURN: assert property (@(posedge clk) disable iff (!rst_n) $fell(ain) |-> !(rout && !aout)); // R7
    end
endmodule

// File: tb/sim_hs_latch_ctrl.sv
// Bench: four controllers (coupled, partly decoupled, fully decoupled, and
// fully decoupled preloaded) run against modelled neighbours over a sweep of
// predecessor and successor response delays.
module sim_hs_latch_ctrl;
    import hs_pkg::*;

    localparam int NDUT   = 4;
    localparam int NITEMS = 6;

    logic clk = 1'b0;
    always #2 clk = ~clk;
    logic rst_n;

    logic rin  [NDUT];
    logic aout [NDUT];
    logic ain  [NDUT];
    logic rout [NDUT];
    logic lt   [NDUT];

    hs_latch_ctrl #(.MODE(HS_SIMPLE), .TOKEN(1'b0)) u0 (.clk(clk), .rst_n(rst_n), .rin(rin[0]), .ain(ain[0]), .rout(rout[0]), .aout(aout[0]), .lt(lt[0]));
    hs_latch_ctrl #(.MODE(HS_SEMI),   .TOKEN(1'b0)) u1 (.clk(clk), .rst_n(rst_n), .rin(rin[1]), .ain(ain[1]), .rout(rout[1]), .aout(aout[1]), .lt(lt[1]));
    hs_latch_ctrl #(.MODE(HS_FULL),   .TOKEN(1'b0)) u2 (.clk(clk), .rst_n(rst_n), .rin(rin[2]), .ain(ain[2]), .rout(rout[2]), .aout(aout[2]), .lt(lt[2]));
    hs_latch_ctrl #(.MODE(HS_FULL),   .TOKEN(1'b1)) u3 (.clk(clk), .rst_n(rst_n), .rin(rin[3]), .ain(ain[3]), .rout(rout[3]), .aout(aout[3]), .lt(lt[3]));

    int total = 0;
    int bad   = 0;

    // per-controller monitors
    int   ain_up [NDUT], rout_up [NDUT], multi [NDUT], bad_ord [NDUT];
    bit   f_ainfall [NDUT], f_cap [NDUT];
    logic p_ain [NDUT], p_rout [NDUT], p_lt [NDUT];

    function automatic int mode_of(input int i);
        return (i == 0) ? 0 : (i == 1) ? 1 : 2;
    endfunction

    function automatic int token_of(input int i);
        return (i == 3) ? 1 : 0;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s dut-check actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // observe one edge's worth of output changes (called at a falling edge)
    task automatic sample_step();
        for (int i = 0; i < NDUT; i++) begin
            int nchg;
            nchg = int'(ain[i] != p_ain[i]) + int'(rout[i] != p_rout[i]) + int'(lt[i] != p_lt[i]);
            if (nchg > 1) multi[i]++;                                        // R2
            if (ain[i] && !p_ain[i]) begin
                ain_up[i]++;
                if (!lt[i]) bad_ord[i]++;                                    // R3
            end
            if (!ain[i] && p_ain[i]) begin
                if (rin[i]) bad_ord[i]++;                                    // R4
                if (rout[i] && !aout[i]) f_ainfall[i] = 1'b1;                // R7
            end
            if (rout[i] && !p_rout[i]) begin
                rout_up[i]++;
                if (!lt[i]) bad_ord[i]++;                                    // R5
            end
            if (!lt[i] && p_lt[i] && !(rout[i] && aout[i])) bad_ord[i]++;    // R6
            if (lt[i] && !p_lt[i] && rout[i]) f_cap[i] = 1'b1;               // R8
            p_ain[i]  = ain[i];
            p_rout[i] = rout[i];
            p_lt[i]   = lt[i];
        end
    endtask

    // modelled neighbours with response delays, then drain and judge
    task automatic run(input int sdel, input int pdel);
        int sent [NDUT];
        int pc [NDUT];
        int sc [NDUT];
        for (int i = 0; i < NDUT; i++) begin
            sent[i] = 0; pc[i] = 0; sc[i] = 0;
            f_ainfall[i] = 1'b0; f_cap[i] = 1'b0;
        end
        for (int cyc = 0; cyc < NITEMS * 80 + 300; cyc++) begin
            @(negedge clk);
            sample_step();
            for (int i = 0; i < NDUT; i++) begin
                if (rin[i] && ain[i]) begin
                    if (pc[i] >= pdel) begin rin[i] = 1'b0; pc[i] = 0; end else pc[i]++;
                end else if (!rin[i] && !ain[i] && sent[i] < NITEMS) begin
                    if (pc[i] >= pdel) begin rin[i] = 1'b1; sent[i]++; pc[i] = 0; end else pc[i]++;
                end else pc[i] = 0;
                if (rout[i] != aout[i]) begin
                    if (sc[i] >= sdel) begin aout[i] = rout[i]; sc[i] = 0; end else sc[i]++;
                end else sc[i] = 0;
            end
        end
        for (int i = 0; i < NDUT; i++) begin
            if (token_of(i) == 1)
                check(rout_up[i] == ain_up[i] + 1, "R9", rout_up[i], ain_up[i] + 1);
            else
                check(rout_up[i] == ain_up[i], "R11", rout_up[i], ain_up[i]);
            check(multi[i] == 0, "R2", multi[i], 0);
            check(bad_ord[i] == 0, "R3 R4 R5 R6 ordering", bad_ord[i], 0);
            if (sdel == 20) begin
                check(f_ainfall[i] == (mode_of(i) != 0), "R7", int'(f_ainfall[i]), int'(mode_of(i) != 0));
                check(f_cap[i] == (mode_of(i) == 2), "R8", int'(f_cap[i]), int'(mode_of(i) == 2));
            end
        end
    endtask

    initial begin
        rst_n = 1'b0;
        for (int i = 0; i < NDUT; i++) begin
            rin[i] = 1'b0; aout[i] = 1'b0;
            ain_up[i] = 0; rout_up[i] = 0; multi[i] = 0; bad_ord[i] = 0;
        end
        repeat (4) @(negedge clk);
        for (int i = 0; i < NDUT; i++) begin
            check(ain[i] == 1'b0 && rout[i] == 1'b0, "R1", int'(ain[i]) + int'(rout[i]), 0);
            check(lt[i] == 1'(token_of(i)), "R1", int'(lt[i]), token_of(i));
            p_ain[i] = ain[i]; p_rout[i] = rout[i]; p_lt[i] = lt[i];
        end
        rst_n = 1'b1;
        for (int i = 0; i < 3; i++) rin[i] = 1'b1;
        repeat (2) begin @(negedge clk); sample_step(); end
        for (int i = 0; i < 3; i++) check(lt[i] == 1'b0, "R10 early", int'(lt[i]), 0);
        @(negedge clk); sample_step();
        for (int i = 0; i < 3; i++) check(lt[i] == 1'b1, "R10", int'(lt[i]), 1);
        check(rout[3] == 1'b1, "R9 preload request", int'(rout[3]), 1);
        check(ain[3] == 1'b0, "R9 no ack", int'(ain[3]), 0);
        for (int s = 0; s < 4; s++) begin
            for (int p = 0; p < 2; p++) begin
                run((s == 0) ? 0 : (s == 1) ? 1 : (s == 2) ? 4 : 20, p * 3);
            end
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule